// File: doc/BRIEF.md
# Programmable Third-Order Sinc Decimation Filter

This block turns the 1-bit output of a sigma-delta modulator into 24-bit conversion words. Each modulator sample enters a chain of three integrators, with a one meaning +1 and a zero meaning -1. The integrators feed three comb stages that run at the decimated rate. The decimation ratio comes from a 12-bit code, so one word is produced for every `code` modulator samples. The comb result is scaled to 24 bits by a shift that depends on the code. It is then given either as unipolar straight binary or as bipolar offset binary.

The filter can be reset in two ways: an external sync level, and a one-cycle channel-change request. Either one clears every integrator, comb delay and counter. Data-ready is then withheld until three full output periods have passed, so the first word seen is fully settled. The modulator-rate strobe is an input, so the block works with any ratio of system clock to modulator rate.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is low, and on the first clock after it, `drdy` is 0 and `result` is 0.
- R2: With sample value x = +1 for a one and -1 for a zero, the settled filter value is y = N²·(2·W − N). Here N is the effective ratio and W is the number of ones in any N consecutive samples, which holds whenever the input pattern repeats with a period dividing N.
- R3: In bipolar mode (`unipolar` = 0), `result` = 0x800000 + y·2^(23−3k), where k = ceil(log2 N). A negative exponent is a floor (arithmetic) right shift. The value saturates to the range 0x000000 to 0xFFFFFF.
- R4: In unipolar mode (`unipolar` = 1), `result` = y·2^(24−3k), with the same shift rule. Negative values give 0x000000 and values above 0xFFFFFF give 0xFFFFFF.
- R5: Once settled, `drdy` pulses high for exactly one clock every N modulator strobes. The pulse comes in the clock after the strobe that completes the period.
- R6: A code below 19 acts as 19 and a code above 4000 acts as 4000, for both the output period and the scaling.
- R7: While `sync_req` is high, no `drdy` pulse occurs and the filter state stays cleared. After release, the first `drdy` follows the 3·N-th strobe counted from release.
- R8: A one-cycle `chan_chg` pulse clears the filter in the same way while `sync_req` is low. The next `drdy` follows the 3·N-th strobe after the pulse.
- R9: After an unsynchronised change of the input pattern, the fourth `drdy` word after the change equals the settled value of the new pattern.
- R10: `result` changes only in a clock where `drdy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_stb | input | 1 | One-clock strobe marking a valid modulator sample |
| mod_bit | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| code_in | input | 12 | Decimation code, clamped to 19..4000 |
| sync_req | input | 1 | Level: holds the filter cleared while high |
| chan_chg | input | 1 | Pulse: restarts the filter as on a channel change |
| unipolar | input | 1 | 1 = unipolar straight binary, 0 = bipolar offset binary |
| result | output | 24 | Latest conversion word |
| drdy | output | 1 | One-cycle strobe: new word on `result` |

## Verification
The bench drives repeating bit patterns whose period divides the ratio, so every settled word has an exact arithmetic value at codes 19, 64, 100 and 4000. At those codes it compares the first word after a clear and the word that follows it. The first word after a clear catches a settling count that is off by one period, which would release an unsettled word or hide one good word. The codes 5 and 4095 catch a missing clamp, which would give the wrong period or a zero-length count. A power-of-two ratio at full density pushes both output codings to their rails, where a missing saturation would wrap to the opposite end. The channel pulse is applied in the middle of a running stream, and the step test switches the input mid-period, which exposes state left behind in the integrators or combs.

// File: rtl/sinc3_pkg.sv
// Shared constants for the third-order sinc decimator.
// Assumes the modulator delivers a 1-bit stream and the ratio fits a 12-bit code.
package sinc3_pkg;
    localparam int SNC_ORDER    = 3;
    localparam int SNC_CODE_W   = 12;
    localparam int SNC_CODE_MIN = 19;
    localparam int SNC_CODE_MAX = 4000;
    localparam int SNC_OUT_W    = 24;
    // Integrator width: sign bit plus ORDER times the bits of the largest ratio.
    localparam int SNC_ACC_W    = 1 + SNC_ORDER * $clog2(SNC_CODE_MAX);
    localparam int SNC_LOG_W    = $clog2(SNC_CODE_W + 1);
endpackage

// File: rtl/sinc3_code_clamp.sv
// Clamps the raw decimation code into the legal ratio range and derives
// k = ceil(log2(ratio)), which sets the output scaling shift.
// Assumes CODE_MIN >= 2 and CODE_MAX < 2**CODE_W. Purely combinational.
module sinc3_code_clamp #(
    parameter int CODE_W   = 12,
    parameter int CODE_MIN = 19,
    parameter int CODE_MAX = 4000,
    parameter int LOG_W    = 4
) (
    input  logic [CODE_W-1:0] code_raw,
    output logic [CODE_W-1:0] ratio,
    output logic [LOG_W-1:0]  ratio_lg
);
    // Limit the code to the legal range.
    always_comb begin
        if (code_raw < CODE_W'(CODE_MIN))
            ratio = CODE_W'(CODE_MIN);
        else if (code_raw > CODE_W'(CODE_MAX))
            ratio = CODE_W'(CODE_MAX);
        else
            ratio = code_raw;
    end

    // Smallest k with 2**k >= ratio, found by a descending scan.
    always_comb begin
        ratio_lg = '0;
        for (int i = CODE_W; i >= 0; i--) begin
            if ((32'd1 << i) >= 32'(ratio))
                ratio_lg = LOG_W'(i);
        end
    end
endmodule

// File: rtl/sinc3_integ.sv
// Cascade of ORDER integrators running at the modulator rate.
// Each stage adds the *new* value of the stage before it, so the chain adds no
// pipeline delay and the last stage's next value is exposed for the combs.
// Assumes two's-complement wraparound in ACC_W bits is acceptable; the comb
// differences recover the exact result as long as |y| < 2**(ACC_W-1).
module sinc3_integ #(
    parameter int ORDER = 3,
    parameter int ACC_W = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stb,
    input  logic             bit_in,
    output logic [ACC_W-1:0] acc_last
);
    logic [ORDER-1:0][ACC_W-1:0] sum_d;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        logic [ACC_W-1:0] acc_q;

        if (g == 0) begin : g_head
            // First stage accumulates +1 or -1 per sample.
            assign sum_d[g] = acc_q + (bit_in ? ACC_W'(1) : {ACC_W{1'b1}});
        end else begin : g_tail
            // Later stages accumulate the updated previous stage.
            assign sum_d[g] = acc_q + sum_d[g-1];
        end

        // Stage register: cleared by reset or filter restart, advanced on strobe.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                acc_q <= '0;
            else if (stb)
                acc_q <= sum_d[g];
        end
    end

    assign acc_last = sum_d[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
// Cascade of ORDER comb (differentiator) stages at the decimated rate.
// Each stage holds one decimated delay. The difference is combinational and
// the delays advance on fire, so dout is valid during the fire cycle.
module sinc3_comb #(
    parameter int ORDER = 3,
    parameter int ACC_W = 37
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    fire,
    input  logic [ACC_W-1:0]        din,
    output logic signed [ACC_W-1:0] dout
);
    logic [ORDER-1:0][ACC_W-1:0] diff;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        logic [ACC_W-1:0] dly_q;
        logic [ACC_W-1:0] stage_in;

        if (g == 0) begin : g_head
            assign stage_in = din;
        end else begin : g_tail
            assign stage_in = diff[g-1];
        end

        assign diff[g] = stage_in - dly_q;

        // Decimated delay: captures this stage's input on each output event.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                dly_q <= '0;
            else if (fire)
                dly_q <= stage_in;
        end
    end

    assign dout = signed'(diff[ORDER-1]);
endmodule

// File: rtl/sinc3_format.sv
// Scales the signed comb result to OUT_W bits and applies the output coding.
// Target exponent is OUT_W-1 for bipolar and OUT_W for unipolar; the value
// is shifted by (target - ORDER*k), then offset (bipolar) and saturated.
// Assumes a full-density input gives |y| <= 2**(ORDER*k). Combinational.
module sinc3_format #(
    parameter int ORDER = 3,
    parameter int ACC_W = 37,
    parameter int OUT_W = 24,
    parameter int LOG_W = 4
) (
    input  logic signed [ACC_W-1:0] y,
    input  logic [LOG_W-1:0]        lg,
    input  logic                    uni,
    output logic [OUT_W-1:0]        res
);
    localparam int WIDE = ACC_W + OUT_W;
    localparam logic signed [WIDE-1:0] MID  =
        {{(WIDE-OUT_W){1'b0}}, 1'b1, {(OUT_W-1){1'b0}}};
    localparam logic signed [WIDE-1:0] FULL =
        {{(WIDE-OUT_W){1'b0}}, {OUT_W{1'b1}}};

    int                     sh_tot;
    int                     tgt;
    logic signed [WIDE-1:0] y_wide;
    logic signed [WIDE-1:0] scaled;
    logic signed [WIDE-1:0] coded;

    // Shift the comb value toward the coding's full-scale exponent.
    always_comb begin
        sh_tot = ORDER * int'(lg);
        tgt    = uni ? OUT_W : OUT_W - 1;
        y_wide = {{OUT_W{y[ACC_W-1]}}, y};
        if (sh_tot <= tgt)
            scaled = y_wide <<< (tgt - sh_tot);
        else
            scaled = y_wide >>> (sh_tot - tgt);
    end

    // Apply the mid-scale offset for bipolar and saturate to the output range.
    always_comb begin
        coded = uni ? scaled : scaled + MID;
        if (coded < 0)
            res = '0;
        else if (coded > FULL)
            res = {OUT_W{1'b1}};
        else
            res = coded[OUT_W-1:0];
    end
endmodule

// File: rtl/sinc3_decim.sv
// Third-order sinc decimator top level.
// Counts modulator strobes to the clamped ratio, fires the comb once per
// period, and withholds data-ready for the first three periods after any
// filter restart (sync level or channel-change pulse).
// Assumes mod_stb is a one-clock pulse and the code changes only with a restart.
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int ORDER    = SNC_ORDER,
    parameter int CODE_W   = SNC_CODE_W,
    parameter int CODE_MIN = SNC_CODE_MIN,
    parameter int CODE_MAX = SNC_CODE_MAX,
    parameter int OUT_W    = SNC_OUT_W,
    parameter int ACC_W    = SNC_ACC_W,
    parameter int LOG_W    = SNC_LOG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_stb,
    input  logic              mod_bit,
    input  logic [CODE_W-1:0] code_in,
    input  logic              sync_req,
    input  logic              chan_chg,
    input  logic              unipolar,
    output logic [OUT_W-1:0]  result,
    output logic              drdy
);
    localparam int SETTLE_W = $clog2(ORDER + 1);
    localparam logic [SETTLE_W-1:0] SETTLE_DONE = SETTLE_W'(ORDER - 1);

    logic                    clr;
    logic                    fire;
    logic [CODE_W-1:0]       ratio;
    logic [LOG_W-1:0]        ratio_lg;
    logic [CODE_W-1:0]       dec_q;
    logic [SETTLE_W-1:0]     settle_q;
    logic [ACC_W-1:0]        integ_out;
    logic signed [ACC_W-1:0] comb_out;
    logic [OUT_W-1:0]        fmt_out;

    assign clr  = sync_req | chan_chg;
    assign fire = mod_stb & ~clr & (dec_q >= ratio - CODE_W'(1));

    sinc3_code_clamp #(
        .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .LOG_W(LOG_W)
    ) clamp_i (
        .code_raw(code_in), .ratio(ratio), .ratio_lg(ratio_lg)
    );

    sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) integ_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .stb(mod_stb),
        .bit_in(mod_bit), .acc_last(integ_out)
    );

    sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) comb_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fire(fire),
        .din(integ_out), .dout(comb_out)
    );

    sinc3_format #(
        .ORDER(ORDER), .ACC_W(ACC_W), .OUT_W(OUT_W), .LOG_W(LOG_W)
    ) fmt_i (
        .y(comb_out), .lg(ratio_lg), .uni(unipolar), .res(fmt_out)
    );

    // Decimation counter: wraps once per ratio strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            dec_q <= '0;
        else if (fire)
            dec_q <= '0;
        else if (mod_stb)
            dec_q <= dec_q + CODE_W'(1);
    end

    // Settling counter: counts output events after a restart, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            settle_q <= '0;
        else if (fire && settle_q <= SETTLE_DONE)
            settle_q <= settle_q + SETTLE_W'(1);
    end

    // Output register: publishes a word and strobe once the filter has settled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy   <= 1'b0;
            result <= '0;
        end else begin
            drdy <= fire && (settle_q >= SETTLE_DONE);
            if (fire && (settle_q >= SETTLE_DONE))
                result <= fmt_out;
        end
    end
endmodule

// File: rtl/sinc3_decim_chk.sv
// Property checker for sinc3_decim, attached by bind below.
// Keeps its own count of strobes since the last restart to check the settling window.
module sinc3_decim_chk
    import sinc3_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mod_stb,
    input logic                 sync_req,
    input logic                 chan_chg,
    input logic                 drdy,
    input logic [SNC_OUT_W-1:0] result
);
    localparam int GAP = SNC_ORDER * SNC_CODE_MIN;
    localparam int CW  = $clog2(GAP + 1) + 1;

    logic [CW-1:0] since_q;

    // Strobes seen since the last restart, saturating at the minimum window.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_req || chan_chg)
            since_q <= '0;
        else if (mod_stb && since_q < CW'(GAP))
            since_q <= since_q + CW'(1);
    end

    AST_DRDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |=> !drdy);                                          // R5
    AST_DRDY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |-> $past(mod_stb));                                 // R5
    AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> !drdy);                                      // R7
    AST_CHAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        chan_chg |=> !drdy);                                      // R8
    AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |-> (since_q >= CW'(GAP)));                          // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy |-> $stable(result));                               // R10
endmodule

bind sinc3_decim sinc3_decim_chk chk_i (.*);

// File: tb/sinc3_decim_tb_top.sv
// Self-checking bench: periodic bit patterns with exactly known sinc3 values.
module sinc3_decim_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mod_stb, mod_bit, sync_req, chan_chg, unipolar;
    logic [11:0] code_in;
    logic [23:0] result;
    logic        drdy;

    always #(CLK_PERIOD/2) clk = ~clk;

    sinc3_decim dut_i (
        .clk(clk), .rst_n(rst_n), .mod_stb(mod_stb), .mod_bit(mod_bit),
        .code_in(code_in), .sync_req(sync_req), .chan_chg(chan_chg),
        .unipolar(unipolar), .result(result), .drdy(drdy)
    );

    int          n_vec = 0;
    int          n_err = 0;
    int          glitch = 0;
    logic        drdy_s;
    logic [23:0] res_s;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, observe at the next falling edge.
    task automatic cyc(input logic stb, input logic b);
        mod_stb = stb;
        mod_bit = b;
        @(negedge clk);
        drdy_s = drdy;
        res_s  = result;
    endtask

    // One modulator sample followed by an idle clock; idle clocks must stay quiet (R5, R10).
    task automatic sample(input bit b, output bit got, output logic [23:0] r);
        cyc(1'b1, b);
        got = drdy_s;
        r   = res_s;
        cyc(1'b0, 1'b0);
        if (drdy_s || res_s != r) glitch++;
    endtask

    function automatic longint expect_val(int n, int w, bit uni);
        longint y, v;
        int k, t;
        y = longint'(n) * n * (2 * w - n);
        k = 0;
        while ((1 << k) < n) k++;
        t = uni ? 24 : 23;
        if (3 * k <= t) v = y <<< (t - 3 * k);
        else            v = y >>> (3 * k - t);
        if (!uni) v += 64'sd8388608;
        if (v < 0) v = 0;
        if (v > 64'sd16777215) v = 64'sd16777215;
        return v;
    endfunction

    function automatic bit pat(int s, int per, int ones);
        return (s % per) < ones;
    endfunction

    task automatic do_clear(input bit use_chan);
        if (use_chan) begin
            chan_chg = 1'b1; cyc(1'b0, 1'b0); chan_chg = 1'b0;
        end else begin
            sync_req = 1'b1; cyc(1'b0, 1'b0); cyc(1'b0, 1'b0); sync_req = 1'b0;
        end
    endtask

    // Restart, feed a pattern, check the first two words and their timing.
    task automatic run_case(input string tag, input int code, input int n, input int per,
                            input int ones, input bit uni, input bit use_chan);
        int s, first, second;
        bit got;
        logic [23:0] r, v1, v2;
        longint exp;
        code_in  = 12'(code);
        unipolar = uni;
        do_clear(use_chan);
        s = 0; first = -1; second = -1; glitch = 0; v1 = '0; v2 = '0;
        while (second < 0 && s < 4 * n + 8) begin
            sample(pat(s, per, ones), got, r);
            s++;
            if (got) begin
                if (first < 0) begin first = s; v1 = r; end
                else begin second = s; v2 = r; end
            end
        end
        exp = expect_val(n, ones * (n / per), uni);
        chk(first == 3 * n, {tag, " R7/R8 first word strobe"}, first, 3 * n);
        chk(longint'(v1) == exp, {tag, " R2 first word"}, v1, exp);
        chk(second - first == n, {tag, " R5 period"}, second - first, n);
        chk(longint'(v2) == exp, {tag, " R2 second word"}, v2, exp);
        chk(glitch == 0, {tag, " R10 quiet between words"}, glitch, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        bit got;
        logic [23:0] r;
        int cnt;
        rst_n = 1'b0; mod_stb = 1'b0; mod_bit = 1'b0; sync_req = 1'b0;
        chan_chg = 1'b0; unipolar = 1'b0; code_in = 12'd19;
        repeat (3) cyc(1'b0, 1'b0);
        chk(drdy_s == 1'b0, "R1 drdy in reset", drdy_s, 0);
        chk(res_s == 24'd0, "R1 result in reset", res_s, 0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0);
        chk(drdy_s == 1'b0 && res_s == 24'd0, "R1 after release", res_s, 0);

        run_case("R3 code19 5/19",        19,   19,   19, 5, 1'b0, 1'b0);
        run_case("R4 code19 ones",        19,   19,   1,  1, 1'b1, 1'b0);
        run_case("R6 code5 clamps to 19", 5,    19,   19, 5, 1'b0, 1'b0);
        run_case("R3 code100 1/4",        100,  100,  4,  1, 1'b0, 1'b0);
        run_case("R4 code100 3/5",        100,  100,  5,  3, 1'b1, 1'b0);
        run_case("R4 negative to zero",   100,  100,  4,  1, 1'b1, 1'b0);
        run_case("R3 code64 top rail",    64,   64,   1,  1, 1'b0, 1'b0);
        run_case("R3 code64 bottom rail", 64,   64,   1,  0, 1'b0, 1'b0);
        run_case("R4 code64 top rail",    64,   64,   1,  1, 1'b1, 1'b0);
        run_case("R8 channel restart",    100,  100,  5,  3, 1'b0, 1'b1);

        // R7: sync held high across many strobes yields no word.
        code_in = 12'd19; unipolar = 1'b0;
        sync_req = 1'b1; cnt = 0;
        for (int i = 0; i < 200; i++) begin
            sample(1'b1, got, r);
            if (got) cnt++;
        end
        sync_req = 1'b0;
        chk(cnt == 0, "R7 no drdy while sync high", cnt, 0);

        // R9: unsynchronised step from all zeros to all ones at code 19.
        do_clear(1'b0);
        cnt = 0;
        while (cnt == 0) begin
            sample(1'b0, got, r);
            if (got) begin
                cnt++;
                chk(longint'(r) == expect_val(19, 0, 1'b0), "R2 code19 zeros", r,
                    expect_val(19, 0, 1'b0));
            end
        end
        for (int i = 0; i < 7; i++) sample(1'b0, got, r);
        cnt = 0;
        while (cnt < 4) begin
            sample(1'b1, got, r);
            if (got) cnt++;
        end
        chk(longint'(r) == expect_val(19, 19, 1'b0), "R9 fourth word after step", r,
            expect_val(19, 19, 1'b0));

        run_case("R3 code4000 1/2",        4000, 4000, 2, 1, 1'b0, 1'b0);
        run_case("R6 code4095 clamps",     4095, 4000, 1, 1, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule